// File: doc/BRIEF.md
# Half-Bridge Protection and Fault-Status Controller

This block sits between the decoded command word of a three-bridge power driver and its six gate drivers. It takes the commanded low-side and high-side enables for each bridge and the digitised fault indications from the analog front end. Those indications are per-switch overcurrent and open-load flags, a supply undervoltage flag, and two thermal comparators, one for prewarning and one for shutdown. From them it decides which gates may conduct, and it assembles the 16-bit status word that the serial interface shifts out.

The overcurrent, open-load and undervoltage flags each pass through a delay filter, a counter that restarts whenever its input drops. The faults recover in different ways. Undervoltage releases the gates as soon as it clears. Thermal shutdown needs the comparator to clear and then a status-reset pulse. Overcurrent either locks the offending switch off or only raises a flag, depending on a command bit. Prewarning is a live bit. A per-bridge gate stage refuses to turn one side on until the other side has been off for a programmable dead time, and it turns both sides off when a command asks for both. All fault inputs are assumed to be synchronous to `clk` already.

Top module: `hb_guard`

## Requirements
- R1: After reset, and while `inh_n` is low, every gate is off and `status` reads all zeros. When `inh_n` returns high, the sticky flags start clear.
- R2: A bridge whose low-side command alone is set drives `gate_lo`, and a bridge whose high-side command alone is set drives `gate_hi`. `status` bit 1+2b shows the low-side gate of bridge b and bit 2+2b shows its high-side gate. Bits 7 to 12 read zero.
- R3: A bridge whose low-side and high-side commands are both set has both gates off.
- R4: Both gates of a bridge are never on at the same time. After a gate turns off, the opposite gate of that bridge turns on no earlier than DEAD_CYC+2 clock edges after the command changed.
- R5: An undervoltage held for UV_DLY sampled edges has no effect. Held for UV_DLY+1 edges, it sets the supply-fail bit (bit 15) and turns every gate off.
- R6: When undervoltage clears, the gates follow the commands again without any reset. Bit 15 stays set until a status reset.
- R7: An open-load flag on a switch that is on, held for more than OL_DLY edges, sets the open-load bit (bit 14), which is sticky. An open-load flag on a switch that is off is ignored.
- R8: Bit 0 follows the prewarning comparator one cycle later and is not cleared by a status reset.
- R9: The shutdown comparator turns every gate off. A status reset while the comparator is still set does not release the gates. Once the comparator has cleared, a status reset restores the gates.
- R10: With `oc_shut_en` high, an overcurrent held for more than OC_DLY edges turns that switch off and sets the short-circuit bit (bit 13). Other switches are unaffected, and the switch stays off after the overcurrent ends.
- R11: With `oc_shut_en` low, such an overcurrent sets bit 13 but leaves every gate as commanded. An overcurrent held for only OC_DLY edges sets nothing.
- R12: A status reset clears bits 13, 14 and 15 and releases switches locked off by overcurrent. If a filtered fault is still present in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inh_n | input | 1 | Low = inhibit: gates off, status cleared |
| cmd_lo | input | N_BR | Commanded low-side enable per bridge |
| cmd_hi | input | N_BR | Commanded high-side enable per bridge |
| oc_shut_en | input | 1 | 1 = overcurrent locks the switch off |
| stat_clr | input | 1 | Status-reset pulse |
| oc_flag | input | 2*N_BR | Overcurrent per switch (2b = low side, 2b+1 = high side) |
| ol_flag | input | 2*N_BR | Current below open-load threshold, per switch |
| uv_flag | input | 1 | Supply undervoltage comparator |
| tw_flag | input | 1 | Thermal prewarning comparator |
| ts_flag | input | 1 | Thermal shutdown comparator |
| gate_lo | output | N_BR | Low-side gate enables |
| gate_hi | output | N_BR | High-side gate enables |
| status | output | 16 | Status word for the serial interface |

## Verification
The hardest case to reach is the edge of each delay filter. A fault held for exactly the filter length must leave no trace, and one held a single cycle longer must latch. The stimulus drives the fault input at a falling clock edge and drops it after a counted number of rising edges, so each side of the boundary is hit exactly. It then counts rising edges in the same way after a command reversal to find the first edge at which the opposite gate may rise. The set-versus-clear race is reached by pulsing status reset while an overcurrent is still held beyond its filter.

// File: rtl/hb_guard_pkg.sv
package hb_guard_pkg;
  localparam int STAT_W = 16;
  localparam int ST_TP  = 0;
  localparam int ST_SW  = 1;   // switch 2b -> low of bridge b, 2b+1 -> high
  localparam int ST_SCD = 13;
  localparam int ST_OPL = 14;
  localparam int ST_PSF = 15;

  function automatic int cnt_w(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/hb_delay_filter.sv
module hb_delay_filter #(
  parameter int DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic raw,
  output logic det
);
  localparam int CW = hb_guard_pkg::cnt_w(DLY);
  localparam logic [CW-1:0] LIM = CW'(DLY);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (kill || !raw)      cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign det = raw && !kill && (cnt_q == LIM);

  // R5/R7/R10: the run counter never passes its limit
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  // R11: an input that drops restarts the count
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> (cnt_q == '0));
endmodule

// File: rtl/hb_sticky.sv
module hb_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;   // set wins over clear
    if (kill) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R12: a pending set always lands
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !kill) |=> q);
endmodule

// File: rtl/hb_leg_gate.sv
module hb_leg_gate #(
  parameter int DEAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic want_lo,
  input  logic want_hi,
  output logic gate_lo,
  output logic gate_hi
);
  localparam int DW = hb_guard_pkg::cnt_w(DEAD);
  localparam logic [DW-1:0] LIM = DW'(DEAD);

  logic [DW-1:0] idle_q, idle_d;
  logic lo_q, hi_q, lo_d, hi_d;
  logic gap_ok;

  assign gap_ok = (idle_q == LIM);

  always_comb begin
    lo_d = !kill && want_lo && !want_hi && !hi_q && (lo_q || gap_ok);
    hi_d = !kill && want_hi && !want_lo && !lo_q && (hi_q || gap_ok);
    if (lo_q || hi_q)  idle_d = '0;
    else if (!gap_ok)  idle_d = idle_q + 1'b1;
    else               idle_d = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      idle_q <= LIM;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      idle_q <= idle_d;
    end
  end

  assign gate_lo = lo_q;
  assign gate_hi = hi_q;

  // R4: no cross conduction
  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_q && hi_q));
  // R4: a rising gate was preceded by the other side being off
  a_r4_gap_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_q) |-> !$past(hi_q));
  a_r4_gap_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> !$past(lo_q));
endmodule

// File: rtl/hb_guard.sv
module hb_guard #(
  parameter int N_BR     = 3,
  parameter int UV_DLY   = 250,
  parameter int OL_DLY   = 1000,
  parameter int OC_DLY   = 500,
  parameter int DEAD_CYC = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inh_n,
  input  logic [N_BR-1:0]   cmd_lo,
  input  logic [N_BR-1:0]   cmd_hi,
  input  logic              oc_shut_en,
  input  logic              stat_clr,
  input  logic [2*N_BR-1:0] oc_flag,
  input  logic [2*N_BR-1:0] ol_flag,
  input  logic              uv_flag,
  input  logic              tw_flag,
  input  logic              ts_flag,
  output logic [N_BR-1:0]   gate_lo,
  output logic [N_BR-1:0]   gate_hi,
  output logic [15:0]       status
);
  import hb_guard_pkg::*;

  localparam int N_SW = 2 * N_BR;  // must not exceed 12 to fit the word

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic kill;
  assign kill = !inh_n;

  logic [N_SW-1:0] sw_on, oc_det, ol_det, lock_q;
  logic uv_det, psf_q, scd_q, opl_q, therm_q, block_all;
  logic tp_q, tp_d;

  genvar gi;
  generate
    for (gi = 0; gi < N_SW; gi++) begin : g_sw
      hb_delay_filter #(.DLY(OC_DLY)) u_oc (
        .clk(clk), .rst_n(rst_sync), .kill(kill),
        .raw(oc_flag[gi]), .det(oc_det[gi]));
      hb_delay_filter #(.DLY(OL_DLY)) u_ol (
        .clk(clk), .rst_n(rst_sync), .kill(kill),
        .raw(ol_flag[gi] && sw_on[gi]), .det(ol_det[gi]));
      hb_sticky u_lock (
        .clk(clk), .rst_n(rst_sync), .kill(kill),
        .set(oc_det[gi] && oc_shut_en), .clr(stat_clr), .q(lock_q[gi]));

      // R10: a locked switch stays dark
      a_r10_locked_off: assert property (@(posedge clk) disable iff (!rst_sync)
        lock_q[gi] |=> !sw_on[gi]);
    end

    for (gi = 0; gi < N_BR; gi++) begin : g_br
      logic want_lo, want_hi;
      assign want_lo = cmd_lo[gi] && !cmd_hi[gi] && !lock_q[2*gi]   && !block_all;
      assign want_hi = cmd_hi[gi] && !cmd_lo[gi] && !lock_q[2*gi+1] && !block_all;
      hb_leg_gate #(.DEAD(DEAD_CYC)) u_leg (
        .clk(clk), .rst_n(rst_sync), .kill(kill),
        .want_lo(want_lo), .want_hi(want_hi),
        .gate_lo(gate_lo[gi]), .gate_hi(gate_hi[gi]));
      assign sw_on[2*gi]   = gate_lo[gi];
      assign sw_on[2*gi+1] = gate_hi[gi];
    end
  endgenerate

  hb_delay_filter #(.DLY(UV_DLY)) u_uv (
    .clk(clk), .rst_n(rst_sync), .kill(kill), .raw(uv_flag), .det(uv_det));

  hb_sticky u_psf (.clk(clk), .rst_n(rst_sync), .kill(kill),
    .set(uv_det), .clr(stat_clr), .q(psf_q));
  hb_sticky u_scd (.clk(clk), .rst_n(rst_sync), .kill(kill),
    .set(|oc_det), .clr(stat_clr), .q(scd_q));
  hb_sticky u_opl (.clk(clk), .rst_n(rst_sync), .kill(kill),
    .set(|ol_det), .clr(stat_clr), .q(opl_q));
  hb_sticky u_thm (.clk(clk), .rst_n(rst_sync), .kill(kill),
    .set(ts_flag), .clr(stat_clr && !ts_flag), .q(therm_q));

  assign block_all = uv_det || therm_q || kill;

  assign tp_d = tw_flag && !kill;
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) tp_q <= 1'b0;
    else           tp_q <= tp_d;
  end

  always_comb begin
    status = '0;
    status[ST_TP] = tp_q;
    for (int i = 0; i < N_SW; i++) status[ST_SW+i] = sw_on[i];
    status[ST_SCD] = scd_q;
    status[ST_OPL] = opl_q;
    status[ST_PSF] = psf_q;
  end

  // R1: one cycle of inhibit empties the whole word
  a_r1_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_sync)
    !inh_n |=> (status == '0));
  // R6: supply-fail holds until a status reset
  a_r6_psf_sticky: assert property (@(posedge clk) disable iff (!rst_sync)
    (status[ST_PSF] && !stat_clr && inh_n) |=> status[ST_PSF]);
  // R9: thermal lock keeps every gate off
  a_r9_therm_dark: assert property (@(posedge clk) disable iff (!rst_sync)
    therm_q |=> (gate_lo == '0 && gate_hi == '0));
  // R8: status reset never drops the prewarning bit
  a_r8_tp_immune: assert property (@(posedge clk) disable iff (!rst_sync)
    (stat_clr && tw_flag && inh_n) |=> status[ST_TP]);
endmodule

// File: tb/hb_guard_test.sv
module hb_guard_test;
  localparam int NB = 3;
  localparam int UVD = 4, OLD = 6, OCD = 3, DT = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n, inh_n, oc_shut_en, stat_clr, uv_flag, tw_flag, ts_flag;
  logic [NB-1:0] cmd_lo, cmd_hi, gate_lo, gate_hi;
  logic [2*NB-1:0] oc_flag, ol_flag;
  logic [15:0] status;

  hb_guard #(.N_BR(NB), .UV_DLY(UVD), .OL_DLY(OLD), .OC_DLY(OCD),
             .DEAD_CYC(DT)) uut (
    .clk(clk), .rst_n(rst_n), .inh_n(inh_n), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .oc_shut_en(oc_shut_en), .stat_clr(stat_clr), .oc_flag(oc_flag),
    .ol_flag(ol_flag), .uv_flag(uv_flag), .tw_flag(tw_flag), .ts_flag(ts_flag),
    .gate_lo(gate_lo), .gate_hi(gate_hi), .status(status));

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // gate ports must agree with the switch bits of the expected word
  task automatic chk_gates(input string req, input logic [15:0] exp);
    logic [15:0] g;
    g = '0;
    for (int b = 0; b < NB; b++) begin
      g[1+2*b] = gate_lo[b];
      g[2+2*b] = gate_hi[b];
    end
    chk(req, g, exp & 16'h007E);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr;
    stat_clr = 1'b1;
    cyc(1);
    stat_clr = 1'b0;
  endtask

  // [43:40] req, [39] inh, [38:36] hi, [35:33] lo, [32] oc_en, [31] clr,
  // [30:25] oc, [24:19] ol, [18] uv, [17] tw, [16] ts, [15:0] expected status
  localparam int NV = 24;
  localparam logic [43:0] VEC [NV] = '{
    {4'd2,  1'b1,3'b000,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0002}, // R2
    {4'd2,  1'b1,3'b110,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0052}, // R2
    {4'd3,  1'b1,3'b110,3'b011,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0042}, // R3
    {4'd8,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b1,1'b0,16'h0043}, // R8
    {4'd8,  1'b1,3'b100,3'b001,1'b0,1'b1,6'h00,6'h00,1'b0,1'b1,1'b0,16'h0043}, // R8
    {4'd8,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0042}, // R8
    {4'd7,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h02,1'b0,1'b0,1'b0,16'h0042}, // R7
    {4'd7,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h01,1'b0,1'b0,1'b0,16'h4042}, // R7
    {4'd7,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h4042}, // R7
    {4'd12, 1'b1,3'b100,3'b001,1'b0,1'b1,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0042}, // R12
    {4'd11, 1'b1,3'b100,3'b001,1'b0,1'b0,6'h20,6'h00,1'b0,1'b0,1'b0,16'h2042}, // R11
    {4'd12, 1'b1,3'b100,3'b001,1'b0,1'b1,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0042}, // R12
    {4'd10, 1'b1,3'b100,3'b001,1'b1,1'b0,6'h20,6'h00,1'b0,1'b0,1'b0,16'h2002}, // R10
    {4'd10, 1'b1,3'b100,3'b001,1'b1,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h2002}, // R10
    {4'd12, 1'b1,3'b100,3'b001,1'b1,1'b1,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0042}, // R12
    {4'd5,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h00,1'b1,1'b0,1'b0,16'h8000}, // R5
    {4'd6,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h8042}, // R6
    {4'd6,  1'b1,3'b100,3'b001,1'b0,1'b1,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0042}, // R6
    {4'd9,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b1,16'h0000}, // R9
    {4'd9,  1'b1,3'b100,3'b001,1'b0,1'b1,6'h00,6'h00,1'b0,1'b0,1'b1,16'h0000}, // R9
    {4'd9,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0000}, // R9
    {4'd9,  1'b1,3'b100,3'b001,1'b0,1'b1,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0042}, // R9
    {4'd1,  1'b0,3'b100,3'b001,1'b0,1'b0,6'h00,6'h01,1'b0,1'b1,1'b0,16'h0000}, // R1
    {4'd1,  1'b1,3'b100,3'b001,1'b0,1'b0,6'h00,6'h00,1'b0,1'b0,1'b0,16'h0042}  // R1
  };

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; inh_n = 1'b1; oc_shut_en = 1'b0; stat_clr = 1'b0;
    uv_flag = 1'b0; tw_flag = 1'b0; ts_flag = 1'b0;
    cmd_lo = '0; cmd_hi = '0; oc_flag = '0; ol_flag = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    chk("R1 reset status", status, 16'h0000);
    chk_gates("R1 reset gates", 16'h0000);

    for (int v = 0; v < NV; v++) begin
      logic [43:0] e;
      string tag;
      e = VEC[v];
      inh_n = e[39]; cmd_hi = e[38:36]; cmd_lo = e[35:33]; oc_shut_en = e[32];
      oc_flag = e[30:25]; ol_flag = e[24:19]; uv_flag = e[18];
      tw_flag = e[17]; ts_flag = e[16];
      if (e[31]) begin
        pulse_clr();
        cyc(11);
      end else begin
        cyc(12);
      end
      tag = $sformatf("R%0d vector %0d", e[43:40], v);
      chk(tag, status, e[15:0]);
      chk_gates(tag, e[15:0]);
    end

    // R5: filter boundary on undervoltage
    uv_flag = 1'b1; cyc(UVD); uv_flag = 1'b0; cyc(4);
    chk("R5 uv short", status, 16'h0042);
    uv_flag = 1'b1; cyc(UVD + 1);
    chk("R5 uv long gates off", {gate_hi, gate_lo}, 6'h00);
    uv_flag = 1'b0; cyc(4);
    chk("R5 uv long flag", status, 16'h8042);
    pulse_clr(); cyc(2);

    // R11: filter boundary on overcurrent, flag only
    oc_flag = 6'h01; cyc(OCD); oc_flag = '0; cyc(4);
    chk("R11 oc short", status, 16'h0042);
    oc_flag = 6'h01; cyc(OCD + 1); oc_flag = '0; cyc(4);
    chk("R11 oc long", status, 16'h2042);
    pulse_clr(); cyc(2);

    // R4: dead time on bridge 0, low side to high side
    cmd_lo = 3'b000; cmd_hi = 3'b101;
    @(posedge clk); #1;
    chk("R4 both off after one edge", {15'd0, gate_lo[0] | gate_hi[0]}, 16'h0000);
    repeat (DT) @(posedge clk);
    #1;
    chk("R4 still off at dead+1", {15'd0, gate_hi[0]}, 16'h0000);
    @(posedge clk); #1;
    chk("R4 high on at dead+2", {15'd0, gate_hi[0]}, 16'h0001);
    cyc(4);
    chk("R4 steady", status, 16'h0044);

    // R12: status reset during a held overcurrent, set wins
    oc_shut_en = 1'b1; oc_flag = 6'h02; cyc(10);
    chk("R12 locked", status, 16'h2040);
    pulse_clr(); cyc(5);
    chk("R12 set wins", status, 16'h2040);
    oc_flag = '0; cyc(2); pulse_clr(); cyc(8);
    chk("R12 released", status, 16'h0044);

    summary();
  end
endmodule